// File: doc/BRIEF.md
# Timer Count-Clock Edge Selector

This block sits in front of one timer channel's counter and decides, in every system clock cycle, whether that counter may advance. It picks one count source from a 3-bit prescaler field: the undivided system clock, one of three prescaled tap levels, a cascade strobe from another channel, or an external clock pin. It then turns the chosen source into a single-cycle count-enable strobe according to a 2-bit edge field that asks for rising, falling or both transitions.

The edge field takes effect only on the slow level sources. On the undivided clock and the cascade strobe it is kept in the register but counting acts as though it held rising edge. While the channel is in phase-counting mode the strobe is held low, because a separate decoder drives the counter then. An 8-bit control byte holds a clear-source field in bits 7:5, the edge field in bits 4:3 and the prescaler field in bits 2:0. It can be loaded only while counting is stopped. A write made while counting is running is dropped and raises an error flag.

Top module: `tcsel_top`

## Requirements
- R1: After reset the control byte reads 8'h00, the count strobe is low and the error flag is low.
- R2: A write presented while `count_run` is low is stored at that clock edge, and all 8 bits read back from the next cycle on, including clear-source bits 7:5, which this block does not otherwise use.
- R3: A write presented while `count_run` is high leaves the control byte unchanged and sets the error flag from the next cycle on. The next accepted write clears the flag.
- R4: With prescaler field 3'b000 the strobe is high in every cycle that `count_run` is high, whatever the edge field holds.
- R5: Prescaler values 3'b001, 3'b010 and 3'b011 select `presc_taps[0]`, `[1]` and `[2]`, and 3'b101 to 3'b111 all select `ext_clk`. Each passes through SYNC_STAGES (default 2) flops. A qualifying change of level sampled at clock edge k raises the strobe for exactly the one cycle after edge k+SYNC_STAGES-1.
- R6: Edge field 2'b00 counts only 0-to-1 changes of a level source, and 2'b01 counts only 1-to-0 changes.
- R7: Edge field 2'b10 or 2'b11 (bit 3 ignored) counts every change of a level source, giving twice as many strobes per source period.
- R8: With prescaler field 3'b100 each cascade pulse gives one strobe, one cycle after it is sampled, and the edge field is treated as 2'b00. A pulse held for several cycles still counts once.
- R9: While `count_run` is low the strobe stays low.
- R10: While `phase_mode` is high the strobe stays low, whatever the source or edge settings.
- R11: Activity on a source that is not selected produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control byte write request |
| ctl_wdata | input | 8 | Control byte write value |
| ctl_rdata | output | 8 | Control byte read-back |
| ctl_err | output | 1 | Set by a write that was refused while counting was running |
| count_run | input | 1 | Counter running; gates the strobe and blocks writes |
| phase_mode | input | 1 | Channel is in phase-counting mode |
| presc_taps | input | 3 | Levels of the divide-by-4, 16 and 64 prescaler taps |
| ext_clk | input | 1 | External count clock level |
| casc_strobe | input | 1 | Overflow/underflow strobe from another channel |
| cnt_en | output | 1 | Single-cycle count-enable strobe |

## Verification
The case where two functions meet is a write attempt that reaches the register in the same cycle as a tap edge moving through the synchronizer while the counter runs. The bench raises a tap level, then presents a write of 8'hFF on the next edge so that it lands one cycle before the strobe is due. It then checks three results. The strobe still arrives in the cycle R5 predicts, the control byte keeps its old value, and the error flag is set. This shows that the refused write neither altered the edge mode under the edge that was in flight nor suppressed that edge.

// File: rtl/tcsel_pkg.sv
package tcsel_pkg;

   localparam int CTL_W   = 8;
   localparam int PSC_W   = 3;
   localparam int EDG_W   = 2;
   localparam int CLR_W   = CTL_W - PSC_W - EDG_W;
   localparam int N_TAPS  = 3;
   localparam int N_LVL   = N_TAPS + 1;

   typedef struct packed {
      logic [CLR_W-1:0] clr;
      logic [EDG_W-1:0] edg;
      logic [PSC_W-1:0] psc;
   } ctl_t;

   typedef enum logic [1:0] {
      SRC_UNDIV = 2'd0,
      SRC_TAP   = 2'd1,
      SRC_CASC  = 2'd2,
      SRC_EXT   = 2'd3
   } src_kind_e;

   function automatic src_kind_e kind_of(input logic [PSC_W-1:0] psc);
      if (psc == 3'b000)      return SRC_UNDIV;
      else if (psc == 3'b100) return SRC_CASC;
      else if (!psc[2])       return SRC_TAP;
      else                    return SRC_EXT;
   endfunction

endpackage

// File: rtl/tcsel_ctl_reg.sv
module tcsel_ctl_reg
   import tcsel_pkg::*;
#(
   parameter logic [CTL_W-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CTL_W-1:0] wdata,
   input  logic             run,
   output ctl_t             ctl,
   output logic             err
);

   logic accept;
   logic refuse;

   assign accept = wr & ~run;
   assign refuse = wr & run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl <= ctl_t'(RST_VAL);
         err <= 1'b0;
      end else begin
         if (accept) begin
            ctl <= ctl_t'(wdata);
            err <= 1'b0;
         end else if (refuse) begin
            err <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/tcsel_sync.sv
module tcsel_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= d;
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/tcsel_edge_det.sv
module tcsel_edge_det (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic rise_en,
   input  logic fall_en,
   output logic hit
);

   logic prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= lvl;
   end

   assign hit = (rise_en & lvl & ~prev) | (fall_en & ~lvl & prev);

endmodule

// File: rtl/tcsel_top.sv
module tcsel_top
   import tcsel_pkg::*;
#(
   parameter int               SYNC_STAGES = 2,
   parameter logic [CTL_W-1:0] CTL_RESET   = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctl_wr,
   input  logic [CTL_W-1:0]  ctl_wdata,
   output logic [CTL_W-1:0]  ctl_rdata,
   output logic              ctl_err,
   input  logic              count_run,
   input  logic              phase_mode,
   input  logic [N_TAPS-1:0] presc_taps,
   input  logic              ext_clk,
   input  logic              casc_strobe,
   output logic              cnt_en
);

   generate
      if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("tcsel_top: SYNC_STAGES must lie in 1..4");
      end
      if (N_TAPS != 3) begin : g_bad_taps
         $error("tcsel_top: prescaler encoding expects three taps");
      end
   endgenerate

   ctl_t      ctl;
   src_kind_e kind;
   logic [N_LVL-1:0] lvl_raw;
   logic [N_LVL-1:0] lvl_sync;
   logic             casc_q;
   logic             sel_lvl;
   logic [1:0]       tap_idx;
   logic [EDG_W-1:0] eff_edg;
   logic             rise_en;
   logic             fall_en;
   logic             hit;
   logic             src_pulse;

   tcsel_ctl_reg #(.RST_VAL(CTL_RESET)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (ctl_wr),
      .wdata (ctl_wdata),
      .run   (count_run),
      .ctl   (ctl),
      .err   (ctl_err)
   );

   assign ctl_rdata = CTL_W'(ctl);
   assign kind      = kind_of(ctl.psc);
   assign lvl_raw   = {ext_clk, presc_taps};

   generate
      for (genvar g = 0; g < N_LVL; g++) begin : g_sync
         tcsel_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (lvl_raw[g]),
            .q     (lvl_sync[g])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) casc_q <= 1'b0;
      else        casc_q <= casc_strobe;
   end

   assign tap_idx = ctl.psc[1:0] - 2'd1;

   always_comb begin
      case (kind)
         SRC_TAP:  sel_lvl = lvl_sync[tap_idx];
         SRC_EXT:  sel_lvl = lvl_sync[N_LVL-1];
         SRC_CASC: sel_lvl = casc_q;
         default:  sel_lvl = 1'b0;
      endcase
   end

   // Fast sources ignore the programmed edge and behave as rising edge.
   always_comb begin
      if (kind == SRC_UNDIV || kind == SRC_CASC) eff_edg = 2'b00;
      else                                       eff_edg = ctl.edg;
   end

   assign rise_en = eff_edg[1] | ~eff_edg[0];
   assign fall_en = eff_edg[1] |  eff_edg[0];

   tcsel_edge_det u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl     (sel_lvl),
      .rise_en (rise_en),
      .fall_en (fall_en),
      .hit     (hit)
   );

   assign src_pulse = (kind == SRC_UNDIV) ? 1'b1 : hit;
   assign cnt_en    = count_run & ~phase_mode & src_pulse;

endmodule

// File: rtl/tcsel_chk.sv
module tcsel_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       ctl_wr,
   input logic [7:0] ctl_wdata,
   input logic [7:0] ctl_rdata,
   input logic       ctl_err,
   input logic       count_run,
   input logic       phase_mode,
   input logic       cnt_en
);

   AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      !count_run |-> !cnt_en);                                    // R9

   AST_PHASE_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
      phase_mode |-> !cnt_en);                                    // R10

   AST_REFUSED_KEEPS_CTL: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && count_run) |=> $stable(ctl_rdata));              // R3

   AST_REFUSED_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && count_run) |=> ctl_err);                         // R3

   AST_ACCEPT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !count_run) |=> (ctl_rdata == $past(ctl_wdata) && !ctl_err)); // R2

   AST_UNDIV_EVERY_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (count_run && !phase_mode && ctl_rdata[2:0] == 3'b000) |-> cnt_en); // R4

endmodule

bind tcsel_top tcsel_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ctl_wr     (ctl_wr),
   .ctl_wdata  (ctl_wdata),
   .ctl_rdata  (ctl_rdata),
   .ctl_err    (ctl_err),
   .count_run  (count_run),
   .phase_mode (phase_mode),
   .cnt_en     (cnt_en)
);

// File: tb/sim_tcsel_top.sv
`timescale 1ns/100ps
module sim_tcsel_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_wr = 1'b0;
   logic [7:0] ctl_wdata = 8'h00;
   logic [7:0] ctl_rdata;
   logic       ctl_err;
   logic       count_run = 1'b0;
   logic       phase_mode = 1'b0;
   logic [3:0] lv = 4'b0000;
   logic       casc_strobe = 1'b0;
   logic       cnt_en;

   int checks = 0;
   int errors = 0;
   int npulse = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   tcsel_top u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .ctl_wr      (ctl_wr),
      .ctl_wdata   (ctl_wdata),
      .ctl_rdata   (ctl_rdata),
      .ctl_err     (ctl_err),
      .count_run   (count_run),
      .phase_mode  (phase_mode),
      .presc_taps  (lv[2:0]),
      .ext_clk     (lv[3]),
      .casc_strobe (casc_strobe),
      .cnt_en      (cnt_en)
   );

   always @(negedge clk) if (cnt_en) npulse = npulse + 1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
      end
   endtask

   task automatic wr(input logic [7:0] v);
      ctl_wr = 1'b1; ctl_wdata = v;
      step(1);
      ctl_wr = 1'b0;
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk(ctl_rdata == 8'h00, "R1 ctl", ctl_rdata, 0);
      chk(cnt_en == 1'b0, "R1 cnt_en", cnt_en, 0);
      chk(ctl_err == 1'b0, "R1 err", ctl_err, 0);
   endtask

   task automatic t_write;
      count_run = 1'b0;
      wr(8'hA5);
      @(negedge clk);
      chk(ctl_rdata == 8'hA5, "R2 readback", ctl_rdata, 8'hA5);
      step(1);
   endtask

   task automatic t_refuse;
      count_run = 1'b1; phase_mode = 1'b1;
      wr(8'h3C);
      @(negedge clk);
      chk(ctl_rdata == 8'hA5, "R3 kept", ctl_rdata, 8'hA5);
      chk(ctl_err == 1'b1, "R3 err set", ctl_err, 1);
      step(1);
      count_run = 1'b0; phase_mode = 1'b0;
      wr(8'h00);
      @(negedge clk);
      chk(ctl_err == 1'b0, "R3 err cleared", ctl_err, 0);
      step(1);
   endtask

   task automatic t_undiv;
      int p0;
      wr(8'h08);
      p0 = npulse;
      count_run = 1'b1;
      step(10);
      count_run = 1'b0;
      step(2);
      chk(npulse - p0 == 10, "R4 undivided", npulse - p0, 10);
   endtask

   // Toggle level source idx three full periods; another source toggles too.
   task automatic t_edges(input logic [7:0] cfg, input int idx, input int exp, input string req);
      int p0;
      int oth;
      oth = (idx + 1) % 4;
      wr(cfg);
      lv = 4'b0000;
      step(4);
      count_run = 1'b1;
      p0 = npulse;
      for (int c = 0; c < 3; c++) begin
         lv[idx] = 1'b1; step(2);
         lv[oth] = 1'b1; casc_strobe = 1'b1; step(1); casc_strobe = 1'b0; step(2);
         lv[idx] = 1'b0; step(2);
         lv[oth] = 1'b0; step(3);
      end
      step(4);
      count_run = 1'b0;
      chk(npulse - p0 == exp, req, npulse - p0, exp);
      step(2);
   endtask

   task automatic t_latency;
      wr(8'h01);
      lv = 4'b0000;
      step(4);
      count_run = 1'b1;
      lv[0] = 1'b1;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      chk(cnt_en == 1'b1, "R5 strobe timing", cnt_en, 1);
      @(negedge clk);
      chk(cnt_en == 1'b0, "R5 single cycle", cnt_en, 0);
      step(1);
      count_run = 1'b0; lv = 4'b0000;
      step(4);
   endtask

   task automatic t_cascade;
      int p0;
      wr(8'h14);
      step(2);
      count_run = 1'b1;
      p0 = npulse;
      for (int c = 0; c < 4; c++) begin
         casc_strobe = 1'b1; step(1); casc_strobe = 1'b0;
         lv[c % 4] = ~lv[c % 4];
         step(3);
      end
      casc_strobe = 1'b1; step(3); casc_strobe = 1'b0; step(4);
      count_run = 1'b0;
      chk(npulse - p0 == 5, "R8 cascade", npulse - p0, 5);
      lv = 4'b0000;
      step(4);
   endtask

   task automatic t_run_gate;
      int p0;
      wr(8'h01);
      count_run = 1'b0;
      p0 = npulse;
      for (int c = 0; c < 3; c++) begin
         lv[0] = 1'b1; step(4); lv[0] = 1'b0; step(4);
      end
      chk(npulse - p0 == 0, "R9 stopped", npulse - p0, 0);
   endtask

   task automatic t_phase;
      int p0;
      wr(8'h00);
      phase_mode = 1'b1; count_run = 1'b1;
      p0 = npulse;
      step(6);
      count_run = 1'b0;
      wr(8'h11);
      count_run = 1'b1;
      lv[0] = 1'b1; step(5); lv[0] = 1'b0; step(5);
      count_run = 1'b0; phase_mode = 1'b0;
      chk(npulse - p0 == 0, "R10 phase mode", npulse - p0, 0);
      step(2);
   endtask

   task automatic t_collision;
      wr(8'h01);
      lv = 4'b0000;
      step(4);
      count_run = 1'b1;
      lv[0] = 1'b1;
      @(posedge clk); #1;
      ctl_wr = 1'b1; ctl_wdata = 8'hFF;
      @(posedge clk); #1;
      ctl_wr = 1'b0;
      @(negedge clk);
      chk(cnt_en == 1'b1, "R5 edge during refused write", cnt_en, 1);
      chk(ctl_err == 1'b1, "R3 err on collision", ctl_err, 1);
      chk(ctl_rdata == 8'h01, "R3 ctl on collision", ctl_rdata, 8'h01);
      step(1);
      count_run = 1'b0; lv = 4'b0000;
      step(2);
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      t_reset();
      t_write();
      t_refuse();
      t_undiv();
      t_latency();
      t_edges(8'h01, 0, 3, "R6 rising tap0");
      t_edges(8'h0A, 1, 3, "R6 falling tap1");
      t_edges(8'h13, 2, 6, "R7 both tap2");
      t_edges(8'h1F, 3, 6, "R7 both ext bit3 set");
      t_edges(8'h07, 3, 3, "R5 ext via 111");
      t_edges(8'h0D, 3, 3, "R11 ext via 101 falling");
      t_edges(8'h02, 1, 3, "R11 tap1 only");
      t_cascade();
      t_run_gate();
      t_phase();
      t_collision();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule